// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the byte-level protocol engine of an SPI NOR flash slave. A separate bit shifter hands it one received byte per transfer while chip select is held low. For every byte it accepts, the block returns one response byte on the following cycle. From the first byte of a selection it decodes the opcode. It then collects address and dummy bytes, and after that it streams array data, forwards program bytes, or plays back a short register reply. It also holds the write-enable latch.

The memory array is reached through a synchronous read port: the sequencer drives an address with a read strobe, and the byte comes back one cycle later. Program and erase work is handed to a separate engine through a valid/ready request port. A request stays stable until the engine takes it.

The byte input is a valid/ready stream. Ready falls while a request is waiting for the engine, so the shifter must hold its byte. The response side has no ready: the shifter must take each response in the cycle it is valid.

Top module: `spinor_cmd_seq`

## Requirements
- R1: While `cs_n` is high the sequencer returns to idle and a partially received command is discarded. Bytes offered while `cs_n` is high have no effect and produce no response. The write-enable latch survives deselection.
- R2: After reset `resp_valid` and `req_valid` are 0 and `xfer_ready` is 1. Each byte accepted with `cs_n` low produces exactly one `resp_valid` pulse in the next cycle.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns one byte equal to 0x02 when the latch is set and 0x00 when it is clear. After that byte, the next byte is decoded as an opcode.
- R4: Opcode 0x9F returns `cfg_mfr`, then `cfg_dev[15:8]`, then `cfg_dev[7:0]`. When `cfg_ext` is nonzero it then also returns `cfg_ext[15:8]` and `cfg_ext[7:0]`. The sequencer then goes back to opcode decoding.
- R5: These opcodes collect 3 bytes: 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8. Opcodes 0x0B, 0x3B and 0x6B collect 4 bytes. Opcode 0xBB collects 4 bytes when `cfg_mfr` is 0xEF or 0x01, and 5 otherwise. Opcode 0xEB collects 6 bytes for those two manufacturers and 8 otherwise. The first three collected bytes form the address, most significant byte first; any further bytes are dummies.
- R6: After a read opcode has collected its bytes, each transfer returns the array byte at the current address. The address then increments, wrapping modulo 2^MEM_AW. Only the low MEM_AW bits of the address are kept.
- R7: After a program opcode (0x02, 0xA2 or 0x32) has collected its bytes, each further byte raises a request with kind 0, the current address and that byte as data, but only if the write-enable latch is set. The address increments with every such byte whether or not a request is raised.
- R8: With the write-enable latch set, erase opcodes raise a request after their third address byte, with data 0. Opcode 0x20 raises kind 1, 0x52 kind 2 and 0xD8 kind 3. Opcode 0xC7 raises kind 4 with address 0 on the opcode byte itself. With the latch clear, none of these raises a request.
- R9: Opcode 0x01 with the latch set consumes one further byte and then clears the latch. With the latch clear, 0x01 is ignored and the next byte is decoded as an opcode.
- R10: Opcode 0x00 and unknown opcodes leave the sequencer in idle. The response byte is 0x00 for every transfer except status, ID and array-read data bytes.
- R11: A raised request keeps `req_valid`, kind, address and data stable until `req_ready` is seen. While it waits, `xfer_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| xfer_valid | input | 1 | Received byte is offered |
| xfer_ready | output | 1 | Sequencer can take a byte |
| xfer_byte | input | 8 | Received byte |
| resp_valid | output | 1 | Response byte valid (one cycle) |
| resp_byte | output | 8 | Response byte for the previous accepted transfer |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | MEM_AW | Array read address |
| mem_rdata | input | 8 | Array data, one cycle after the strobe |
| req_valid | output | 1 | Program/erase request pending |
| req_ready | input | 1 | Engine takes the request |
| req_kind | output | 3 | 0 program, 1 erase 4 KiB, 2 erase 32 KiB, 3 erase sector, 4 erase chip |
| req_addr | output | MEM_AW | Request address |
| req_data | output | 8 | Program byte (0 for erases) |
| cfg_mfr | input | 8 | Manufacturer ID byte |
| cfg_dev | input | 16 | Device ID bytes |
| cfg_ext | input | 16 | Extended ID, 0 when absent |

## Verification
The assertions take for granted that the array answers a read strobe with data exactly one cycle later. They also assume the engine drives `req_ready` as a plain level, and that the three configuration inputs change only while `cs_n` is high. The stimulus meets these conditions. Its array model registers a computed byte for every strobe. It changes `cfg_mfr` and `cfg_ext` only between selections. It moves `req_ready` in the middle of the clock-high phase, so that a stalled request is held for several cycles before the engine takes it.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

  typedef enum logic [3:0] {
    CLS_NONE, CLS_READ, CLS_PROG, CLS_ERASE, CLS_WEN,
    CLS_WDIS, CLS_RDSR, CLS_WRSR, CLS_RDID, CLS_CHIP
  } op_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_STREAM, ST_PROGRAM, ST_REPLY
  } seq_st_e;

  typedef enum logic [2:0] {
    RQ_PROG  = 3'd0,
    RQ_ER4K  = 3'd1,
    RQ_ER32K = 3'd2,
    RQ_ERSEC = 3'd3,
    RQ_CHIP  = 3'd4
  } req_kind_e;

endpackage

// File: rtl/spinor_decode.sv
module spinor_decode
  import spinor_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       opcode,
  input  logic [7:0]       mfr,
  output op_cls_e          cls,
  output logic [CNT_W-1:0] nbytes,
  output req_kind_e        ekind
);
  logic short_io;  // manufacturers with the shorter dual/quad-io preamble
  assign short_io = (mfr == 8'hEF) || (mfr == 8'h01);

  always_comb begin
    cls    = CLS_NONE;
    nbytes = '0;
    ekind  = RQ_PROG;
    unique case (opcode)
      8'h03:                   begin cls = CLS_READ; nbytes = CNT_W'(3); end
      8'h0B, 8'h3B, 8'h6B:     begin cls = CLS_READ; nbytes = CNT_W'(4); end
      8'hBB: begin cls = CLS_READ; nbytes = short_io ? CNT_W'(4) : CNT_W'(5); end
      8'hEB: begin cls = CLS_READ; nbytes = short_io ? CNT_W'(6) : CNT_W'(8); end
      8'h02, 8'hA2, 8'h32:     begin cls = CLS_PROG; nbytes = CNT_W'(3); end
      8'h20: begin cls = CLS_ERASE; nbytes = CNT_W'(3); ekind = RQ_ER4K;  end
      8'h52: begin cls = CLS_ERASE; nbytes = CNT_W'(3); ekind = RQ_ER32K; end
      8'hD8: begin cls = CLS_ERASE; nbytes = CNT_W'(3); ekind = RQ_ERSEC; end
      8'h06: cls = CLS_WEN;
      8'h04: cls = CLS_WDIS;
      8'h05: cls = CLS_RDSR;
      8'h01: begin cls = CLS_WRSR; nbytes = CNT_W'(1); end
      8'h9F: cls = CLS_RDID;
      8'hC7: begin cls = CLS_CHIP; ekind = RQ_CHIP; end
      default: cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/spinor_reply.sv
module spinor_reply (
  input  logic        is_status,
  input  logic        wel,
  input  logic [2:0]  idx,
  input  logic [7:0]  mfr,
  input  logic [15:0] dev,
  input  logic [15:0] ext,
  output logic [7:0]  byte_out,
  output logic [2:0]  id_len
);
  assign id_len = (ext != 16'h0000) ? 3'd5 : 3'd3;

  always_comb begin
    if (is_status) begin
      byte_out = {6'b0, wel, 1'b0};
    end else begin
      unique case (idx)
        3'd0:    byte_out = mfr;
        3'd1:    byte_out = dev[15:8];
        3'd2:    byte_out = dev[7:0];
        3'd3:    byte_out = ext[15:8];
        3'd4:    byte_out = ext[7:0];
        default: byte_out = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/spinor_req.sv
module spinor_req
  import spinor_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  req_kind_e     ld_kind,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic          ready,
  output logic          valid,
  output req_kind_e     kind,
  output logic [AW-1:0] addr,
  output logic [7:0]    data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      kind  <= RQ_PROG;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      kind  <= ld_kind;
      addr  <= ld_addr;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(kind) && $stable(addr) && $stable(data)); // R11
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid); // R11
endmodule

// File: rtl/spinor_cmd_seq.sv
module spinor_cmd_seq
  import spinor_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              xfer_valid,
  output logic              xfer_ready,
  input  logic [7:0]        xfer_byte,
  output logic              resp_valid,
  output logic [7:0]        resp_byte,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_kind,
  output logic [MEM_AW-1:0] req_addr,
  output logic [7:0]        req_data,
  input  logic [7:0]        cfg_mfr,
  input  logic [15:0]       cfg_dev,
  input  logic [15:0]       cfg_ext
);
  localparam logic [CNT_W-1:0] ADDR_BYTES = CNT_W'(3);

  seq_st_e           st;
  op_cls_e           cur_cls;
  req_kind_e         cur_ekind;
  logic [CNT_W-1:0]  cnt, need;
  logic [MEM_AW-1:0] ptr, ptr_shift;
  logic              wel;
  logic [2:0]        ridx, rlen;
  logic              rstat;
  logic              resp_valid_q, resp_mem_q;
  logic [7:0]        resp_q;
  logic              fire, last_byte;

  op_cls_e           dec_cls;
  logic [CNT_W-1:0]  dec_nbytes;
  req_kind_e         dec_ekind;
  logic [7:0]        rep_byte;
  logic [2:0]        id_len;

  logic              ld;
  req_kind_e         ld_kind, rq_kind;
  logic [MEM_AW-1:0] ld_addr;
  logic [7:0]        ld_data;

  spinor_decode #(.CNT_W(CNT_W)) u_dec (
    .opcode(xfer_byte), .mfr(cfg_mfr),
    .cls(dec_cls), .nbytes(dec_nbytes), .ekind(dec_ekind)
  );

  spinor_reply u_rep (
    .is_status(rstat), .wel(wel), .idx(ridx),
    .mfr(cfg_mfr), .dev(cfg_dev), .ext(cfg_ext),
    .byte_out(rep_byte), .id_len(id_len)
  );

  spinor_req #(.AW(MEM_AW)) u_req (
    .clk(clk), .rst_n(rst_n), .load(ld),
    .ld_kind(ld_kind), .ld_addr(ld_addr), .ld_data(ld_data),
    .ready(req_ready), .valid(req_valid),
    .kind(rq_kind), .addr(req_addr), .data(req_data)
  );
  assign req_kind = rq_kind;

  // Byte intake stalls while the engine has not taken a request.
  assign xfer_ready = !req_valid;
  assign fire       = xfer_valid && xfer_ready && !cs_n;
  // Address bytes shift straight into the array pointer, MSB first.
  assign ptr_shift  = MEM_AW'({ptr, xfer_byte});
  assign last_byte  = (cnt + CNT_W'(1)) == need;

  assign mem_rd_en  = fire && (st == ST_STREAM);
  assign mem_addr   = ptr;
  assign resp_valid = resp_valid_q;
  assign resp_byte  = resp_mem_q ? mem_rdata : resp_q;

  always_comb begin
    ld      = 1'b0;
    ld_kind = RQ_PROG;
    ld_addr = ptr;
    ld_data = 8'h00;
    if (fire && wel) begin
      unique case (st)
        ST_IDLE:
          if (dec_cls == CLS_CHIP) begin
            ld = 1'b1; ld_kind = RQ_CHIP; ld_addr = '0;
          end
        ST_COLLECT:
          if (cur_cls == CLS_ERASE && last_byte) begin
            ld = 1'b1; ld_kind = cur_ekind; ld_addr = ptr_shift;
          end
        ST_PROGRAM: begin
          ld = 1'b1; ld_data = xfer_byte;
        end
        default: ld = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cur_cls      <= CLS_NONE;
      cur_ekind    <= RQ_PROG;
      cnt          <= '0;
      need         <= '0;
      ptr          <= '0;
      wel          <= 1'b0;
      ridx         <= '0;
      rlen         <= '0;
      rstat        <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_mem_q   <= 1'b0;
      resp_q       <= '0;
    end else begin
      resp_valid_q <= fire;
      resp_mem_q   <= fire && (st == ST_STREAM);
      resp_q       <= (fire && st == ST_REPLY) ? rep_byte : 8'h00;
      if (cs_n) begin
        st   <= ST_IDLE;
        cnt  <= '0;
        ridx <= '0;
      end else if (fire) begin
        unique case (st)
          ST_IDLE: begin
            cnt       <= '0;
            ridx      <= '0;
            cur_cls   <= dec_cls;
            cur_ekind <= dec_ekind;
            need      <= dec_nbytes;
            unique case (dec_cls)
              CLS_READ, CLS_PROG, CLS_ERASE: st <= ST_COLLECT;
              CLS_WRSR: if (wel) st <= ST_COLLECT;
              CLS_WEN:  wel <= 1'b1;
              CLS_WDIS: wel <= 1'b0;
              CLS_RDSR: begin rstat <= 1'b1; rlen <= 3'd1;   st <= ST_REPLY; end
              CLS_RDID: begin rstat <= 1'b0; rlen <= id_len; st <= ST_REPLY; end
              default: st <= ST_IDLE;
            endcase
          end
          ST_COLLECT: begin
            if (cnt < ADDR_BYTES) ptr <= ptr_shift;
            cnt <= cnt + CNT_W'(1);
            if (last_byte) begin
              unique case (cur_cls)
                CLS_READ: st <= ST_STREAM;
                CLS_PROG: st <= ST_PROGRAM;
                CLS_WRSR: begin wel <= 1'b0; st <= ST_IDLE; end
                default:  st <= ST_IDLE;
              endcase
            end
          end
          ST_STREAM, ST_PROGRAM: ptr <= ptr + MEM_AW'(1);
          ST_REPLY: begin
            if (ridx == rlen - 3'd1) begin
              st   <= ST_IDLE;
              ridx <= '0;
            end else begin
              ridx <= ridx + 3'd1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> st == ST_IDLE); // R1
  AST_QUIET_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !$past(st == ST_STREAM || st == ST_REPLY) |-> resp_byte == 8'h00); // R10
  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(wel)); // R8
  AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_addr == MEM_AW'($past(mem_addr) + 1'b1)); // R6
endmodule

// File: tb/tb_spinor_cmd_seq.sv
module tb_spinor_cmd_seq;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          xfer_valid = 1'b0;
  logic          xfer_ready;
  logic [7:0]    xfer_byte = 8'h00;
  logic          resp_valid;
  logic [7:0]    resp_byte;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;
  logic          req_valid;
  logic          req_ready = 1'b1;
  logic [2:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic [7:0]    cfg_mfr = 8'h20;
  logic [15:0]   cfg_dev = 16'h2014;
  logic [15:0]   cfg_ext = 16'h0000;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0]  exp_resp[$];
  string       resp_tag[$];
  logic [20:0] exp_req[$];
  string       req_tag[$];

  always #2 clk = ~clk;  // 250 MHz

  spinor_cmd_seq #(.MEM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_byte(xfer_byte),
    .resp_valid(resp_valid), .resp_byte(resp_byte),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data),
    .cfg_mfr(cfg_mfr), .cfg_dev(cfg_dev), .cfg_ext(cfg_ext)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd7 + 16'd53;
    return t[7:0];
  endfunction

  // array model: data one cycle after the strobe
  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_resp.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected response %0h expected none", resp_byte);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_resp.pop_front();
        t = resp_tag.pop_front();
        chk(t, 32'(resp_byte), 32'(e));
      end
    end
  end

  // request monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_req.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7: actual unexpected request %0h expected none",
                 {req_kind, req_addr, req_data});
      end else begin
        logic [20:0] e;
        string t;
        e = exp_req.pop_front();
        t = req_tag.pop_front();
        chk(t, 32'({req_kind, req_addr, req_data}), 32'(e));
      end
    end
  end

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_byte  = b;
    while (!xfer_ready) @(negedge clk);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic put(input string tag, input logic [7:0] b, input logic [7:0] e);
    exp_resp.push_back(e);
    resp_tag.push_back(tag);
    xfer(b);
  endtask

  task automatic want_req(input string tag, input logic [2:0] k,
                          input logic [AW-1:0] a, input logic [7:0] d);
    exp_req.push_back({k, a, d});
    req_tag.push_back(tag);
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic status(input string tag, input logic [7:0] e);
    sel(); put(tag, 8'h05, 8'h00); put(tag, 8'h00, e); desel();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset resp_valid", 32'(resp_valid), 0);
    chk("R2 reset req_valid", 32'(req_valid), 0);
    chk("R2 reset xfer_ready", 32'(xfer_ready), 1);

    // R1: byte offered while deselected is ignored
    xfer(8'h06);
    status("R1 deselected write-enable ignored", 8'h00);

    // R1: partial read command discarded by deselect
    sel(); put("R1 partial", 8'h03, 8'h00); put("R1 partial", 8'h00, 8'h00); desel();
    sel();
    put("R1 fresh opcode", 8'h9F, 8'h00);
    put("R4 id mfr", 8'h00, 8'h20);
    put("R4 id dev hi", 8'h00, 8'h20);
    put("R4 id dev lo", 8'h00, 8'h14);
    put("R4 back to idle", 8'h05, 8'h00);
    put("R3 status clear", 8'h00, 8'h00);
    desel();

    // R3: latch set / clear
    sel(); put("R3 wren", 8'h06, 8'h00); desel();
    sel();
    put("R3 rdsr", 8'h05, 8'h00);
    put("R3 status set", 8'h00, 8'h02);
    put("R3 wrdi after reply", 8'h04, 8'h00);
    put("R3 rdsr", 8'h05, 8'h00);
    put("R3 status cleared", 8'h00, 8'h00);
    desel();

    // R4: extended ID
    cfg_ext = 16'h4D01;
    sel();
    put("R4 op", 8'h9F, 8'h00);
    put("R4 ext mfr", 8'h00, 8'h20);
    put("R4 ext dev hi", 8'h00, 8'h20);
    put("R4 ext dev lo", 8'h00, 8'h14);
    put("R4 ext hi", 8'h00, 8'h4D);
    put("R4 ext lo", 8'h00, 8'h01);
    put("R4 idle after ext", 8'h05, 8'h00);
    put("R4 status", 8'h00, 8'h00);
    desel();

    // R10: null and unknown opcodes
    sel();
    put("R10 null op", 8'h00, 8'h00);
    put("R10 unknown op", 8'h77, 8'h00);
    put("R10 still idle", 8'h05, 8'h00);
    put("R10 status", 8'h00, 8'h00);
    desel();

    // R6: read with truncation and wrap
    sel();
    put("R6 op", 8'h03, 8'h00);
    put("R6 a2", 8'hAB, 8'h00); put("R6 a1", 8'h03, 8'h00); put("R6 a0", 8'hFE, 8'h00);
    put("R6 data 3fe", 8'h00, pat(10'h3FE));
    put("R6 data 3ff", 8'h00, pat(10'h3FF));
    put("R6 wrap 000", 8'h00, pat(10'h000));
    put("R6 data 001", 8'h00, pat(10'h001));
    desel();

    // R5: fast read with one dummy
    sel();
    put("R5 0B", 8'h0B, 8'h00);
    put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h40, 8'h00);
    put("R5 0B dummy", 8'h5A, 8'h00);
    put("R5 0B data", 8'h00, pat(10'h040));
    put("R5 0B data+1", 8'h00, pat(10'h041));
    desel();

    // R5: dual-io read, both manufacturer groups
    cfg_mfr = 8'hEF;
    sel();
    put("R5 BB short", 8'hBB, 8'h00);
    put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h80, 8'h00);
    put("R5 BB short dummy", 8'h00, 8'h00);
    put("R5 BB short data", 8'h00, pat(10'h080));
    desel();
    cfg_mfr = 8'h20;
    sel();
    put("R5 BB long", 8'hBB, 8'h00);
    put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h80, 8'h00);
    for (int i = 0; i < 2; i++) put("R5 BB long dummy", 8'h00, 8'h00);
    put("R5 BB long data", 8'h00, pat(10'h080));
    desel();

    // R5: quad-io read, both manufacturer groups
    cfg_mfr = 8'h01;
    sel();
    put("R5 EB short", 8'hEB, 8'h00);
    put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h00, 8'h00); put("R5 a", 8'hC0, 8'h00);
    for (int i = 0; i < 3; i++) put("R5 EB short dummy", 8'h00, 8'h00);
    put("R5 EB short data", 8'h00, pat(10'h0C0));
    desel();
    cfg_mfr = 8'h20;
    sel();
    put("R5 EB long", 8'hEB, 8'h00);
    put("R5 a", 8'h00, 8'h00); put("R5 a", 8'h00, 8'h00); put("R5 a", 8'hC0, 8'h00);
    for (int i = 0; i < 5; i++) put("R5 EB long dummy", 8'h00, 8'h00);
    put("R5 EB long data", 8'h00, pat(10'h0C0));
    desel();

    // R7: program with latch set
    sel(); put("R7 wren", 8'h06, 8'h00); desel();
    want_req("R7 prog byte 0", 3'd0, 10'h100, 8'hAA);
    want_req("R7 prog byte 1", 3'd0, 10'h101, 8'h55);
    sel();
    put("R7 op", 8'h02, 8'h00);
    put("R7 a", 8'h00, 8'h00); put("R7 a", 8'h01, 8'h00); put("R7 a", 8'h00, 8'h00);
    put("R7 d0", 8'hAA, 8'h00); put("R7 d1", 8'h55, 8'h00);
    desel();
    chk("R7 both program requests taken", 32'(exp_req.size()), 0);

    // R7: program with latch clear
    sel(); put("R7 wrdi", 8'h04, 8'h00); desel();
    sel();
    put("R7 op", 8'h32, 8'h00);
    put("R7 a", 8'h00, 8'h00); put("R7 a", 8'h02, 8'h00); put("R7 a", 8'h00, 8'h00);
    put("R7 d", 8'h11, 8'h00);
    desel();
    chk("R7 no request without latch", 32'(req_valid), 0);

    // R8 + R11: erase with engine stalled
    sel(); put("R8 wren", 8'h06, 8'h00); desel();
    req_ready = 1'b0;
    want_req("R8 erase 4k", 3'd1, 10'h123, 8'h00);
    sel();
    put("R8 op", 8'h20, 8'h00);
    put("R8 a", 8'h00, 8'h00); put("R8 a", 8'h01, 8'h00); put("R8 a", 8'h23, 8'h00);
    chk("R8 erase request raised", 32'(req_valid), 1);
    chk("R11 intake stalled", 32'(xfer_ready), 0);
    repeat (3) @(negedge clk);
    chk("R11 request still valid", 32'(req_valid), 1);
    chk("R11 address held", 32'(req_addr), 32'h123);
    @(posedge clk); #1 req_ready = 1'b1;
    desel();

    want_req("R8 erase 32k", 3'd2, 10'h200, 8'h00);
    sel();
    put("R8 op", 8'h52, 8'h00);
    put("R8 a", 8'h00, 8'h00); put("R8 a", 8'h02, 8'h00); put("R8 a", 8'h00, 8'h00);
    desel();
    want_req("R8 erase sector", 3'd3, 10'h300, 8'h00);
    sel();
    put("R8 op", 8'hD8, 8'h00);
    put("R8 a", 8'h00, 8'h00); put("R8 a", 8'h03, 8'h00); put("R8 a", 8'h00, 8'h00);
    desel();
    want_req("R8 chip erase", 3'd4, 10'h000, 8'h00);
    sel(); put("R8 chip op", 8'hC7, 8'h00); desel();
    chk("R8 all erase requests taken", 32'(exp_req.size()), 0);

    // R8: erases with latch clear
    sel(); put("R8 wrdi", 8'h04, 8'h00); desel();
    sel();
    put("R8 op", 8'hD8, 8'h00);
    put("R8 a", 8'h00, 8'h00); put("R8 a", 8'h03, 8'h00); put("R8 a", 8'h00, 8'h00);
    desel();
    sel(); put("R8 chip op", 8'hC7, 8'h00); desel();
    chk("R8 no erase without latch", 32'(req_valid), 0);

    // R9: write status with latch set
    sel(); put("R9 wren", 8'h06, 8'h00); desel();
    sel();
    put("R9 op", 8'h01, 8'h00);
    put("R9 value", 8'h7C, 8'h00);
    put("R9 rdsr", 8'h05, 8'h00);
    put("R9 latch cleared", 8'h00, 8'h00);
    desel();

    // R9: write status with latch clear is ignored
    sel();
    put("R9 ignored op", 8'h01, 8'h00);
    put("R9 next is opcode", 8'h9F, 8'h00);
    put("R9 id", 8'h00, 8'h20);
    put("R9 id", 8'h00, 8'h20);
    put("R9 id", 8'h00, 8'h14);
    put("R9 id", 8'h00, 8'h4D);
    put("R9 id", 8'h00, 8'h01);
    desel();

    repeat (4) @(negedge clk);
    chk("R2 all responses seen", 32'(exp_resp.size()), 0);
    chk("R11 all requests seen", 32'(exp_req.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule